// File: doc/BRIEF.md
# Interrupt vector ring writer

This block turns interrupt events raised by on-chip agents into fixed-size 128-bit records. It stores them in a circular buffer in host-visible memory. Each event carries a source identifier, a source payload, a ring identifier, a VM identifier and an address-space identifier. The block packs these into one record and writes it through a plain memory write port. It then advances a byte-granular write pointer. Host software drains records and hands back a read pointer through a small register port. While unread records exist, the block holds a level interrupt request. It also emits a one-cycle message-style interrupt pulse.

The ring keeps accepting events when it is full, so the oldest records are overwritten. In that case the block sets a sticky overflow flag, which software sees in bit 0 of the reported write pointer, and software can resume reading just past the write pointer. Optionally, every pointer advance is followed by a 32-bit mirror write of the reported write pointer to a programmed memory location, so software can poll memory instead of the register port. The memory itself, the bus fabric and message delivery lie outside the block.

Top module: `ivr_top`

## Requirements
- R1: Each record is 128 bits: source id in [7:0], the 28-bit source data in [59:32], ring id in [71:64], VM id in [79:72], 16-bit address-space id in [95:80], and every other bit zero.
- R2: Read and write pointers are byte offsets with bits [3:0] always zero. Each stored record advances the write pointer by 16, modulo the ring size. The ring size in bytes is 4 << S, where S is the size field (see R11), for S from 3 to PTR_W-2; values outside that range are clamped.
- R3: While the ring is active, irq_level is high exactly when the write and read pointers differ or the overflow flag is set.
- R4: A record is written to byte address (base register << 8) + write pointer, with mem_wr_mask = 4'b1111. The write pointer advances in the cycle the write is acknowledged.
- R5: When overflow detection is enabled and a record advance lands the write pointer on the read pointer while the two pointers differed, a sticky overflow flag is set. The record is still written. The flag reads as bit 0 of the write-pointer register and persists across later advances.
- R6: Writing the ring control register with bit 7 set clears the overflow flag. With overflow detection disabled (control bit 6 low), the flag is never set.
- R7: The ring is active only when global enable (global register bit 0) and ring enable (control bit 0) are both set. While inactive, ev_ready and irq_level are low, offered events are ignored, and no memory write starts.
- R8: With writeback enabled (control bit 8), each record write is followed by a second write of the reported write-pointer value. That second write goes to the 32-bit word at {writeback high [7:0], writeback low [31:2], 2'b00}: the data sits in dword lane addr[3:2] and only that lane's mask bit is set. With writeback disabled, each event yields exactly one memory write.
- R9: irq_msg pulses for one cycle when the pending condition of R3 rises. With rearm (global register bit 1) set, irq_msg also pulses after a read-pointer write that leaves the condition true.
- R10: ev_ready is low while any memory write is outstanding. mem_wr_addr, mem_wr_data and mem_wr_mask hold steady from the rise of mem_wr_valid until mem_wr_ack.
- R11: Register addresses: 0 global control, 1 ring control (bit 0 enable, [5:1] size S, bit 6 overflow enable, bit 7 overflow clear, which reads as 0, bit 8 writeback enable), 2 ring base, 3 writeback low, 4 writeback high, 5 read pointer, 6 write pointer. Writing a pointer register loads it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Event accepted when high with ev_valid |
| ev_src_id | input | 8 | Event source identifier |
| ev_src_data | input | 28 | Event payload |
| ev_ring_id | input | 8 | Originating ring identifier |
| ev_vm_id | input | 8 | VM identifier |
| ev_pasid | input | 16 | Process address-space identifier |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_wr_valid | output | 1 | Memory write request |
| mem_wr_ack | input | 1 | Memory write accepted |
| mem_wr_addr | output | ADDR_W | Byte address of the write |
| mem_wr_data | output | 128 | Write data |
| mem_wr_mask | output | 4 | Per-dword write enables |
| irq_level | output | 1 | Level interrupt request while entries are unread |
| irq_msg | output | 1 | One-cycle message interrupt pulse |

## Verification
The packing is driven with a small table of event vectors. A mixed pattern, an all-ones pattern, an all-zero pattern and a pattern with single high bits near field edges tell a misplaced or truncated field apart from a correct one. Walking that table once around a four-entry ring shows each pointer step and the wrap back to zero, and the writeback data and lane confirm every step. A second pass without draining fills the ring to show the sticky flag and the overwrite. Later passes clear the flag, disable detection, drop writeback, toggle rearm and disable the ring, so each control bit is seen to change only its own behaviour.

// File: rtl/ivr_pkg.sv
package ivr_pkg;

    localparam int VEC_W     = 128;
    localparam int VEC_BYTES = 16;
    localparam int LANES     = VEC_W / 32;

    // register addresses
    localparam logic [2:0] RA_GLOBAL = 3'd0;
    localparam logic [2:0] RA_RING   = 3'd1;
    localparam logic [2:0] RA_BASE   = 3'd2;
    localparam logic [2:0] RA_WBLO   = 3'd3;
    localparam logic [2:0] RA_WBHI   = 3'd4;
    localparam logic [2:0] RA_RPTR   = 3'd5;
    localparam logic [2:0] RA_WPTR   = 3'd6;

    // ring control field positions
    localparam int RC_EN      = 0;
    localparam int RC_SZ_LSB  = 1;
    localparam int RC_SZ_W    = 5;
    localparam int RC_OVF_EN  = 6;
    localparam int RC_OVF_CLR = 7;
    localparam int RC_WB_EN   = 8;

    // global control field positions
    localparam int GC_INTR  = 0;
    localparam int GC_REARM = 1;

    typedef struct packed {
        logic [7:0]  src_id;
        logic [27:0] src_data;
        logic [7:0]  ring_id;
        logic [7:0]  vm_id;
        logic [15:0] pasid;
    } ivr_event_t;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_VEC  = 2'd1,
        SEQ_WB   = 2'd2
    } seq_state_t;

    function automatic logic [VEC_W-1:0] pack_vector(input ivr_event_t e);
        logic [VEC_W-1:0] v;
        v         = '0;
        v[7:0]    = e.src_id;
        v[59:32]  = e.src_data;
        v[71:64]  = e.ring_id;
        v[79:72]  = e.vm_id;
        v[95:80]  = e.pasid;
        return v;
    endfunction

    // clamp the log2 ring size (in dwords) to [3, hi]
    function automatic logic [5:0] clamp_size(input logic [RC_SZ_W-1:0] sz,
                                              input int unsigned hi);
        if (sz < 5'd3)
            return 6'd3;
        if (int'(sz) > int'(hi))
            return 6'(hi);
        return {1'b0, sz};
    endfunction

endpackage

// File: rtl/ivr_regs.sv
module ivr_regs
    import ivr_pkg::*;
#(
    parameter int PTR_W   = 18,
    parameter int WB_HI_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [2:0]           addr,
    input  logic [31:0]          wdata,
    input  logic [PTR_W-1:4]     ptr_mask_hi,
    input  logic [31:0]          wptr_report,
    output logic                 intr_en,
    output logic                 rearm_en,
    output logic                 ring_en,
    output logic                 ovf_en,
    output logic                 wb_en,
    output logic                 ovf_clr,
    output logic [RC_SZ_W-1:0]   size_log2,
    output logic [31:0]          base,
    output logic [31:2]          wb_lo,
    output logic [WB_HI_W-1:0]   wb_hi,
    output logic [PTR_W-1:0]     rptr,
    output logic                 rptr_wr_q,
    output logic                 wptr_wr,
    output logic [PTR_W-1:4]     wptr_wdata,
    output logic [31:0]          rdata
);

    localparam int PAD = 32 - PTR_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            intr_en   <= 1'b0;
            rearm_en  <= 1'b0;
            ring_en   <= 1'b0;
            ovf_en    <= 1'b0;
            wb_en     <= 1'b0;
            size_log2 <= '0;
            base      <= '0;
            wb_lo     <= '0;
            wb_hi     <= '0;
            rptr      <= '0;
            rptr_wr_q <= 1'b0;
        end else begin
            rptr_wr_q <= wr_en && (addr == RA_RPTR);
            if (wr_en) begin
                case (addr)
                    RA_GLOBAL: begin
                        intr_en  <= wdata[GC_INTR];
                        rearm_en <= wdata[GC_REARM];
                    end
                    RA_RING: begin
                        ring_en   <= wdata[RC_EN];
                        size_log2 <= wdata[RC_SZ_LSB +: RC_SZ_W];
                        ovf_en    <= wdata[RC_OVF_EN];
                        wb_en     <= wdata[RC_WB_EN];
                    end
                    RA_BASE: base  <= wdata;
                    RA_WBLO: wb_lo <= wdata[31:2];
                    RA_WBHI: wb_hi <= wdata[WB_HI_W-1:0];
                    RA_RPTR: rptr  <= {wdata[PTR_W-1:4] & ptr_mask_hi, 4'b0000};
                    default: ;
                endcase
            end
        end
    end

    assign ovf_clr    = wr_en && (addr == RA_RING) && wdata[RC_OVF_CLR];
    assign wptr_wr    = wr_en && (addr == RA_WPTR);
    assign wptr_wdata = wdata[PTR_W-1:4];

    always_comb begin
        case (addr)
            RA_GLOBAL: rdata = {30'b0, rearm_en, intr_en};
            RA_RING:   rdata = {23'b0, wb_en, 1'b0, ovf_en, size_log2, ring_en};
            RA_BASE:   rdata = base;
            RA_WBLO:   rdata = {wb_lo, 2'b00};
            RA_WBHI:   rdata = {{(32-WB_HI_W){1'b0}}, wb_hi};
            RA_RPTR:   rdata = {{PAD{1'b0}}, rptr};
            RA_WPTR:   rdata = wptr_report;
            default:   rdata = '0;
        endcase
    end

    // R2: the read pointer stays record aligned
    assert_rptr_align_R2: assert property (@(posedge clk) disable iff (rst)
        rptr[3:0] == 4'b0000);

endmodule

// File: rtl/ivr_ptr.sv
module ivr_ptr
    import ivr_pkg::*;
#(
    parameter int PTR_W = 18
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [RC_SZ_W-1:0]   size_log2,
    input  logic                 adv,
    input  logic [PTR_W-1:0]     rptr,
    input  logic                 ovf_en,
    input  logic                 ovf_clr,
    input  logic                 sw_wr,
    input  logic [PTR_W-1:4]     sw_data,
    output logic [PTR_W-1:0]     wptr,
    output logic                 ovf,
    output logic [PTR_W-1:0]     ptr_mask,
    output logic [31:0]          report,
    output logic [31:0]          report_next
);

    localparam int PAD    = 32 - PTR_W;
    localparam int SZ_MAX = PTR_W - 2;

    logic [5:0]       eff_log2;
    logic [PTR_W-1:0] step;
    logic [PTR_W-1:0] wptr_d;
    logic             ovf_d;

    assign eff_log2 = clamp_size(size_log2, SZ_MAX);

    // byte mask of the ring: 2^(eff_log2+2) bytes
    for (genvar g = 0; g < PTR_W; g++) begin : g_mask
        assign ptr_mask[g] = (6'(g) < (eff_log2 + 6'd2));
    end

    assign step = (wptr + PTR_W'(VEC_BYTES)) & ptr_mask;

    always_comb begin
        wptr_d = wptr;
        ovf_d  = ovf;
        if (ovf_clr)
            ovf_d = 1'b0;
        if (sw_wr)
            wptr_d = {sw_data & ptr_mask[PTR_W-1:4], 4'b0000};
        if (adv) begin
            wptr_d = step;
            if (ovf_en && (wptr != rptr) && (step == rptr))
                ovf_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            ovf  <= 1'b0;
        end else begin
            wptr <= wptr_d;
            ovf  <= ovf_d;
        end
    end

    assign report      = {{PAD{1'b0}}, wptr[PTR_W-1:1], ovf};
    assign report_next = {{PAD{1'b0}}, wptr_d[PTR_W-1:1], ovf_d};

    // R2: write pointer stays record aligned
    assert_wptr_align_R2: assert property (@(posedge clk) disable iff (rst)
        wptr[3:0] == 4'b0000);

    // R5: overflow flag is sticky until a clear
    assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (ovf && !ovf_clr) |=> ovf);

    // R6: a clear without a concurrent advance drops the flag
    assert_ovf_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (ovf_clr && !adv) |=> !ovf);

    // R6: detection disabled never raises the flag
    assert_ovf_gate_R6: assert property (@(posedge clk) disable iff (rst)
        (!ovf && !ovf_en) |=> !ovf);

endmodule

// File: rtl/ivr_seq.sv
module ivr_seq
    import ivr_pkg::*;
#(
    parameter int PTR_W  = 18,
    parameter int ADDR_W = 40
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 active,
    input  logic                 ev_valid,
    input  ivr_event_t           ev,
    input  logic [PTR_W-1:0]     wptr,
    input  logic [31:0]          base,
    input  logic                 wb_en,
    input  logic [ADDR_W-1:2]    wb_addr,
    input  logic [31:0]          report_next,
    input  logic                 mem_wr_ack,
    output logic                 ev_ready,
    output logic                 adv,
    output logic                 mem_wr_valid,
    output logic [ADDR_W-1:0]    mem_wr_addr,
    output logic [VEC_W-1:0]     mem_wr_data,
    output logic [LANES-1:0]     mem_wr_mask
);

    localparam int BASE_SHIFT = 8;

    seq_state_t        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [VEC_W-1:0]  data_q;
    logic [LANES-1:0]  mask_q;
    logic [ADDR_W-1:0] base_addr;
    logic [1:0]        lane;

    assign base_addr = ADDR_W'({base, {BASE_SHIFT{1'b0}}});
    assign lane      = wb_addr[3:2];

    assign ev_ready     = active && (state_q == SEQ_IDLE);
    assign adv          = (state_q == SEQ_VEC) && mem_wr_ack;
    assign mem_wr_valid = (state_q != SEQ_IDLE);
    assign mem_wr_addr  = addr_q;
    assign mem_wr_data  = data_q;
    assign mem_wr_mask  = mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            addr_q  <= '0;
            data_q  <= '0;
            mask_q  <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (ev_valid && ev_ready) begin
                        data_q  <= pack_vector(ev);
                        addr_q  <= base_addr + ADDR_W'(wptr);
                        mask_q  <= '1;
                        state_q <= SEQ_VEC;
                    end
                end
                SEQ_VEC: begin
                    if (mem_wr_ack) begin
                        if (wb_en) begin
                            addr_q  <= {wb_addr, 2'b00};
                            data_q  <= VEC_W'(report_next) << {lane, 5'b00000};
                            mask_q  <= LANES'(1) << lane;
                            state_q <= SEQ_WB;
                        end else begin
                            state_q <= SEQ_IDLE;
                        end
                    end
                end
                SEQ_WB: begin
                    if (mem_wr_ack)
                        state_q <= SEQ_IDLE;
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // R10: no new event while a write is in flight
    assert_ready_idle_R10: assert property (@(posedge clk) disable iff (rst)
        ev_ready |-> !mem_wr_valid);

    // R10: request holds steady until acknowledged
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_valid && !mem_wr_ack) |=>
            (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)
             && $stable(mem_wr_mask)));

    // R8: a writeback write enables exactly one dword lane
    assert_wb_lane_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_WB) |-> $onehot0(mem_wr_mask) && (mem_wr_mask != '0));

endmodule

// File: rtl/ivr_irq.sv
module ivr_irq #(
    parameter int PTR_W = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic [PTR_W-1:0] wptr,
    input  logic [PTR_W-1:0] rptr,
    input  logic             ovf,
    input  logic             rearm_en,
    input  logic             rptr_wr_q,
    output logic             irq_level,
    output logic             irq_msg
);

    logic pending;
    logic pend_q;

    assign pending   = active && ((wptr != rptr) || ovf);
    assign irq_level = pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= 1'b0;
            irq_msg <= 1'b0;
        end else begin
            pend_q  <= pending;
            irq_msg <= (pending && !pend_q) || (pending && rearm_en && rptr_wr_q);
        end
    end

    // R7: no request while the ring is inactive
    assert_irq_off_R7: assert property (@(posedge clk) disable iff (rst)
        !active |-> !irq_level);

    // R9: without rearm, message pulses never come back to back
    assert_msg_single_R9: assert property (@(posedge clk) disable iff (rst)
        (irq_msg && !rearm_en) |=> !irq_msg);

endmodule

// File: rtl/ivr_top.sv
module ivr_top
    import ivr_pkg::*;
#(
    parameter int PTR_W  = 18,
    parameter int ADDR_W = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    output logic              ev_ready,
    input  logic [7:0]        ev_src_id,
    input  logic [27:0]       ev_src_data,
    input  logic [7:0]        ev_ring_id,
    input  logic [7:0]        ev_vm_id,
    input  logic [15:0]       ev_pasid,
    input  logic              reg_wr_en,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_wr_valid,
    input  logic              mem_wr_ack,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [127:0]      mem_wr_data,
    output logic [3:0]        mem_wr_mask,
    output logic              irq_level,
    output logic              irq_msg
);

    localparam int WB_HI_W = ADDR_W - 32;

    logic                 intr_en, rearm_en, ring_en, ovf_en, wb_en, ovf_clr;
    logic [RC_SZ_W-1:0]   size_log2;
    logic [31:0]          base;
    logic [31:2]          wb_lo;
    logic [WB_HI_W-1:0]   wb_hi;
    logic [PTR_W-1:0]     rptr, wptr, ptr_mask;
    logic                 rptr_wr_q, wptr_wr, adv, ovf, active;
    logic [PTR_W-1:4]     wptr_wdata;
    logic [31:0]          report, report_next;
    ivr_event_t           ev;

    assign active = intr_en && ring_en;
    assign ev     = '{src_id: ev_src_id, src_data: ev_src_data, ring_id: ev_ring_id,
                      vm_id: ev_vm_id, pasid: ev_pasid};

    ivr_regs #(.PTR_W(PTR_W), .WB_HI_W(WB_HI_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(reg_wr_en), .addr(reg_addr), .wdata(reg_wdata),
        .ptr_mask_hi(ptr_mask[PTR_W-1:4]), .wptr_report(report),
        .intr_en(intr_en), .rearm_en(rearm_en), .ring_en(ring_en), .ovf_en(ovf_en),
        .wb_en(wb_en), .ovf_clr(ovf_clr), .size_log2(size_log2), .base(base),
        .wb_lo(wb_lo), .wb_hi(wb_hi), .rptr(rptr), .rptr_wr_q(rptr_wr_q),
        .wptr_wr(wptr_wr), .wptr_wdata(wptr_wdata), .rdata(reg_rdata)
    );

    ivr_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk(clk), .rst(rst), .size_log2(size_log2), .adv(adv), .rptr(rptr),
        .ovf_en(ovf_en), .ovf_clr(ovf_clr), .sw_wr(wptr_wr), .sw_data(wptr_wdata),
        .wptr(wptr), .ovf(ovf), .ptr_mask(ptr_mask), .report(report),
        .report_next(report_next)
    );

    ivr_seq #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst(rst), .active(active), .ev_valid(ev_valid), .ev(ev),
        .wptr(wptr), .base(base), .wb_en(wb_en), .wb_addr({wb_hi, wb_lo}),
        .report_next(report_next), .mem_wr_ack(mem_wr_ack), .ev_ready(ev_ready),
        .adv(adv), .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .mem_wr_mask(mem_wr_mask)
    );

    ivr_irq #(.PTR_W(PTR_W)) u_irq (
        .clk(clk), .rst(rst), .active(active), .wptr(wptr), .rptr(rptr), .ovf(ovf),
        .rearm_en(rearm_en), .rptr_wr_q(rptr_wr_q), .irq_level(irq_level),
        .irq_msg(irq_msg)
    );

endmodule

// File: tb/ivr_top_bench.sv
module ivr_top_bench;

    typedef struct packed {
        logic [7:0]   s;
        logic [27:0]  d;
        logic [7:0]   r;
        logic [7:0]   v;
        logic [15:0]  p;
        logic [127:0] exp;
    } vec_row_t;

    localparam vec_row_t TBL [4] = '{
        '{8'hA5, 28'h1234567, 8'h01, 8'h02, 16'hBEEF,
          128'h00000000_BEEF0201_01234567_000000A5},
        '{8'hFF, 28'hFFFFFFF, 8'hFF, 8'hFF, 16'hFFFF,
          128'h00000000_FFFFFFFF_0FFFFFFF_000000FF},
        '{8'h00, 28'h0000000, 8'h00, 8'h00, 16'h0000,
          128'h0},
        '{8'h3C, 28'h8000001, 8'h80, 8'h40, 16'h0001,
          128'h00000000_00014080_08000001_0000003C}
    };

    localparam logic [31:0] CTRL_ON = 32'h149; // en, size 4, ovf en, wb en

    logic         clk = 0, rst = 1;
    logic         ev_valid = 0, ev_ready;
    logic [7:0]   ev_src_id = 0, ev_ring_id = 0, ev_vm_id = 0;
    logic [27:0]  ev_src_data = 0;
    logic [15:0]  ev_pasid = 0;
    logic         reg_wr_en = 0;
    logic [2:0]   reg_addr = 0;
    logic [31:0]  reg_wdata = 0, reg_rdata;
    logic         mem_wr_valid, mem_wr_ack;
    logic [39:0]  mem_wr_addr;
    logic [127:0] mem_wr_data;
    logic [3:0]   mem_wr_mask;
    logic         irq_level, irq_msg;

    int checks = 0, bad = 0, wr_count = 0, msg_count = 0;
    logic [39:0]  last_vaddr, last_waddr;
    logic [127:0] last_vdata, last_wdata;
    logic [3:0]   last_wmask;
    bit           done = 0;

    always #4 clk = ~clk;

    ivr_top u_ivr_top (
        .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_ready(ev_ready),
        .ev_src_id(ev_src_id), .ev_src_data(ev_src_data), .ev_ring_id(ev_ring_id),
        .ev_vm_id(ev_vm_id), .ev_pasid(ev_pasid), .reg_wr_en(reg_wr_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_wr_valid(mem_wr_valid), .mem_wr_ack(mem_wr_ack), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .mem_wr_mask(mem_wr_mask), .irq_level(irq_level),
        .irq_msg(irq_msg)
    );

    // memory model: acknowledges one cycle after a request is seen
    always @(posedge clk) begin
        if (rst) begin
            mem_wr_ack <= 1'b0;
        end else begin
            mem_wr_ack <= mem_wr_valid && !mem_wr_ack;
            if (mem_wr_valid && mem_wr_ack) begin
                wr_count <= wr_count + 1;
                if (mem_wr_mask == 4'hF) begin
                    last_vaddr <= mem_wr_addr;
                    last_vdata <= mem_wr_data;
                end else begin
                    last_waddr <= mem_wr_addr;
                    last_wdata <= mem_wr_data;
                    last_wmask <= mem_wr_mask;
                end
            end
            if (irq_msg)
                msg_count <= msg_count + 1;
        end
    end

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic send_row(input vec_row_t r, input bit chk_busy);
        @(negedge clk);
        ev_src_id = r.s; ev_src_data = r.d; ev_ring_id = r.r;
        ev_vm_id = r.v; ev_pasid = r.p; ev_valid = 1;
        while (!ev_ready) @(negedge clk);
        @(negedge clk);
        ev_valid = 0;
        if (chk_busy)
            chk("R10 busy ready/valid", {ev_ready, mem_wr_valid}, 2'b01);
        while (!ev_ready) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; bad++;
        $display("FAIL watchdog act=hung exp=finished");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        int m0, w0;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // reset state
        reg_rd(3'd6, rd); chk("R11 reset wptr", rd, 0);
        reg_rd(3'd5, rd); chk("R11 reset rptr", rd, 0);
        chk("R7 reset outputs", {ev_ready, irq_level, mem_wr_valid}, 3'b000);

        // only global enable: ring still inactive
        reg_wr(3'd0, 32'h1);
        chk("R7 half enable ready", ev_ready, 0);
        reg_wr(3'd2, 32'h1000);
        reg_wr(3'd3, 32'h2008);
        reg_wr(3'd4, 32'h12);
        reg_wr(3'd1, CTRL_ON);
        chk("R7 full enable ready", ev_ready, 1);
        reg_rd(3'd1, rd); chk("R11 ctrl readback", rd, CTRL_ON);

        // table walk: one lap of a 4-entry ring, drained each step
        for (int i = 0; i < 4; i++) begin
            logic [31:0] we;
            we = 32'((16 * (i + 1)) % 64);
            send_row(TBL[i], i == 0);
            chk("R1 packed record", last_vdata, TBL[i].exp);
            chk("R4 record address", last_vaddr, 40'h10_0000 + 40'(16 * i));
            reg_rd(3'd6, rd); chk("R2 wptr step/wrap", rd, we);
            chk("R8 wb address", last_waddr, 40'h12_0000_2008);
            chk("R8 wb lane mask", last_wmask, 4'b0100);
            chk("R8 wb data", last_wdata[95:64], we);
            chk("R3 irq pending", irq_level, 1);
            reg_wr(3'd5, we);
            chk("R3 irq drained", irq_level, 0);
        end
        repeat (3) @(negedge clk);
        chk("R9 one pulse per rise", msg_count, 4);

        // fill without draining: 4th record overflows
        for (int j = 0; j < 4; j++) send_row(TBL[j], 0);
        reg_rd(3'd6, rd); chk("R5 overflow flag in wptr", rd, 32'h1);
        chk("R5 irq with equal pointers", irq_level, 1);
        chk("R5 overwrite still written", last_vaddr, 40'h10_0030);
        chk("R8 wb carries flag", last_wdata[95:64], 32'h1);
        send_row(TBL[0], 0);
        reg_rd(3'd6, rd); chk("R5 flag sticky", rd, 32'h11);

        // clear, then detection disabled
        reg_wr(3'd1, CTRL_ON | 32'h80);
        reg_rd(3'd6, rd); chk("R6 flag cleared", rd, 32'h10);
        reg_rd(3'd1, rd); chk("R11 clear bit reads zero", rd, CTRL_ON);
        reg_wr(3'd1, 32'h109);
        reg_wr(3'd5, 32'd32);
        send_row(TBL[1], 0);
        reg_rd(3'd6, rd); chk("R6 no flag when disabled", rd, 32'h20);

        // writeback off: one write per event
        reg_wr(3'd1, 32'h009);
        w0 = wr_count;
        send_row(TBL[2], 0);
        @(negedge clk);
        chk("R8 single write without wb", wr_count - w0, 1);
        reg_rd(3'd6, rd); chk("R2 wptr after step", rd, 32'h30);
        reg_wr(3'd5, 32'h30);

        // rearm
        reg_wr(3'd0, 32'h3);
        m0 = msg_count;
        send_row(TBL[3], 0);
        send_row(TBL[0], 0);
        repeat (3) @(negedge clk);
        chk("R9 rise pulse", msg_count - m0, 1);
        reg_wr(3'd5, 32'h0);
        repeat (3) @(negedge clk);
        chk("R9 rearm pulse", msg_count - m0, 2);
        reg_wr(3'd0, 32'h1);
        reg_wr(3'd5, 32'h0);
        repeat (3) @(negedge clk);
        chk("R9 no pulse without rearm", msg_count - m0, 2);
        chk("R3 still pending", irq_level, 1);

        // disable: outputs drop, events ignored
        reg_wr(3'd0, 32'h0);
        chk("R7 irq off when disabled", irq_level, 0);
        chk("R7 ready off when disabled", ev_ready, 0);
        w0 = wr_count;
        @(negedge clk);
        ev_valid = 1;
        repeat (10) @(negedge clk);
        ev_valid = 0;
        chk("R7 no write when disabled", {31'b0, mem_wr_valid} + 32'(wr_count - w0), 0);
        reg_rd(3'd6, rd); chk("R7 wptr untouched", rd, 32'h10);
        reg_wr(3'd5, 32'h0);
        reg_wr(3'd6, 32'h0);
        reg_rd(3'd6, rd); chk("R11 wptr load zero", rd, 0);

        finish_run();
    end

endmodule